// File: doc/BRIEF.md
# Access-Aware Glitch-Free CPU Clock Switch

This block produces the clock of an 8-bit CPU from one of two free-running sources: a slow base clock and a fast clock. The two sources have no fixed phase or frequency relation. Typical pairings are the base rate with five or four times the base rate, or a 2 MHz hardware rate with a 3.58 MHz CPU rate. When the selection changes, the output clock stays high from the last rising edge of the old source until the new source takes over. The CPU therefore sees one longer high phase, keeps its bus state through it, and then continues at the new rate. The output never carries a runt pulse.

The selection is made per bus cycle by an access classifier that runs on the output clock. On the first output-clock rising edge where the memory-request or I/O-request strobe is active, the classifier latches its decision and keeps it until the strobes are released. Ordinary memory cycles that an external decoder marks as local fast memory run on the fast clock. I/O cycles, refresh cycles and memory cycles outside the fast region run on the base clock, because they reach timing-sensitive mainboard parts such as peripherals, DRAM, ROM and video memory. Between bus cycles the last selection is kept.

Top module: `cpu_speed_switch`

## Requirements
- R1: While rstN is low at rising edges of both sources (synchronous, active low), the base clock is selected and fastActive is 0. After reset is released with no strobe active, cpuClk runs at the base clock period.
- R2: cpuClk never has a high or low pulse shorter than the shorter half-period of the two sources. During a changeover it is held high until the new source drives it.
- R3: At no time are both sources enabled onto cpuClk.
- R4: A memory cycle (memReqN=0, ioReqN=1, refreshN=1) sampled with fastRegion=1 switches cpuClk to the fast clock period.
- R5: A memory cycle sampled with fastRegion=0 switches to, or stays on, the base clock.
- R6: An I/O cycle (ioReqN=0) selects the base clock whatever the value of fastRegion.
- R7: A refresh cycle (memReqN=0 with refreshN=0) selects the base clock whatever the value of fastRegion.
- R8: The selection is taken at the first cpuClk rising edge with a strobe active. Later changes of fastRegion or refreshN while the strobe stays active have no effect.
- R9: With no strobe active, changes of fastRegion leave the current selection unchanged.
- R10: fastActive is 1 exactly while the fast source is the one enabled onto cpuClk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkBase | input | 1 | Slow base clock source |
| clkFast | input | 1 | Fast clock source, asynchronous to clkBase |
| rstN | input | 1 | Synchronous active-low reset, seen in each clock domain |
| memReqN | input | 1 | CPU memory-request strobe, active low |
| ioReqN | input | 1 | CPU I/O-request strobe, active low |
| refreshN | input | 1 | CPU refresh strobe, active low |
| fastRegion | input | 1 | Decoder flag: current address is in local fast memory |
| cpuClk | output | 1 | Switched CPU clock |
| fastActive | output | 1 | 1 when the fast source drives cpuClk |

## Verification
A wrong latched selection shows up at fastActive and in the cpuClk period within a few edges of each source after the strobe is sampled. A selection that changes inside a bus cycle shows up as a status that disagrees with the value sampled at the start of the cycle. A broken handoff between the two enable chains shows up as a cpuClk pulse shorter than either source half-period, or as a clock that stops. Both are caught by edge-time measurement on every cpuClk transition and by per-cycle comparison with a behavioural selection model.

// File: rtl/speed_switch_pkg.sv
`timescale 1ns/1ps
package speed_switch_pkg;
  localparam int N_SRC = 2;         // index 0 = base, 1 = fast
  localparam int SYNC_STAGES = 2;   // enable synchronizer depth per source

  typedef struct packed {
    logic wantFast;                 // classifier request for the fast source
  } ctrlStrobes_t;
endpackage

// File: rtl/access_classifier.sv
`timescale 1ns/1ps
module access_classifier
  import speed_switch_pkg::*;
(
  input  logic         cpuClk,
  input  logic         rstN,
  input  logic         memReqN,
  input  logic         ioReqN,
  input  logic         refreshN,
  input  logic         fastRegion,
  output ctrlStrobes_t ctrl
);
  logic strobeOn;
  logic held;
  logic wantFastQ;
  logic decideFast;

  assign strobeOn   = !memReqN || !ioReqN;
  // Only plain memory cycles inside the fast region may use the fast source.
  assign decideFast = !memReqN && ioReqN && refreshN && fastRegion;

  always_ff @(posedge cpuClk) begin
    if (!rstN) begin
      wantFastQ <= 1'b0;
      held      <= 1'b0;
    end else if (strobeOn) begin
      if (!held) begin
        wantFastQ <= decideFast;
        held      <= 1'b1;
      end
    end else begin
      held <= 1'b0;
    end
  end

  assign ctrl.wantFast = wantFastQ;
endmodule

// File: rtl/clock_lane.sv
`timescale 1ns/1ps
module clock_lane #(
  parameter int STAGES   = 2,
  parameter bit RESET_ON = 1'b0
) (
  input  logic srcClk,
  input  logic rstN,
  input  logic wantMe,
  input  logic otherEn,
  output logic laneEn
);
  logic [STAGES-1:0] chain;

  // Enable moves only at this source's rising edge, i.e. while it is high,
  // so the high-forcing gate below cannot chop a pulse.
  always_ff @(posedge srcClk) begin
    if (!rstN) chain <= {STAGES{RESET_ON}};
    else       chain <= {chain[STAGES-2:0], wantMe & ~otherEn};
  end

  assign laneEn = chain[STAGES-1];
endmodule

// File: rtl/clock_gate_path.sv
`timescale 1ns/1ps
module clock_gate_path
  import speed_switch_pkg::*;
(
  input  logic [N_SRC-1:0] srcClk,
  input  logic             rstN,
  input  ctrlStrobes_t     ctrl,
  output logic             cpuClk,
  output logic [N_SRC-1:0] laneEn
);
  logic [N_SRC-1:0] gated;

  for (genvar i = 0; i < N_SRC; i++) begin : g_lane
    localparam bit IS_FAST = (i == 1);
    logic wantMe;
    assign wantMe = IS_FAST ? ctrl.wantFast : ~ctrl.wantFast;

    clock_lane #(.STAGES(SYNC_STAGES), .RESET_ON(!IS_FAST)) u_lane (
      .srcClk (srcClk[i]),
      .rstN   (rstN),
      .wantMe (wantMe),
      .otherEn(laneEn[N_SRC-1-i]),
      .laneEn (laneEn[i])
    );

    // A disabled source contributes a constant high.
    assign gated[i] = srcClk[i] | ~laneEn[i];
  end

  assign cpuClk = &gated;
endmodule

// File: rtl/cpu_speed_switch.sv
`timescale 1ns/1ps
module cpu_speed_switch
  import speed_switch_pkg::*;
(
  input  logic clkBase,
  input  logic clkFast,
  input  logic rstN,
  input  logic memReqN,
  input  logic ioReqN,
  input  logic refreshN,
  input  logic fastRegion,
  output logic cpuClk,
  output logic fastActive
);
  ctrlStrobes_t     ctrl;
  logic [N_SRC-1:0] laneEn;
  logic             wantFast;

  access_classifier u_ctrl (
    .cpuClk    (cpuClk),
    .rstN      (rstN),
    .memReqN   (memReqN),
    .ioReqN    (ioReqN),
    .refreshN  (refreshN),
    .fastRegion(fastRegion),
    .ctrl      (ctrl)
  );

  clock_gate_path u_path (
    .srcClk({clkFast, clkBase}),
    .rstN  (rstN),
    .ctrl  (ctrl),
    .cpuClk(cpuClk),
    .laneEn(laneEn)
  );

  assign wantFast   = ctrl.wantFast;
  assign fastActive = laneEn[1];
endmodule

// File: rtl/cpu_speed_switch_checker.sv
`timescale 1ns/1ps
module cpu_speed_switch_checker (
  input logic       clkBase,
  input logic       clkFast,
  input logic       cpuClk,
  input logic       rstN,
  input logic       memReqN,
  input logic       ioReqN,
  input logic       refreshN,
  input logic [1:0] laneEn,
  input logic       wantFast
);
  // R3: the two enables never overlap, seen from either source
  p_one_source_r3: assert property (@(posedge clkFast) disable iff (!rstN)
    !(laneEn[0] && laneEn[1]));
  p_one_source_base_r3: assert property (@(posedge clkBase) disable iff (!rstN)
    !(laneEn[0] && laneEn[1]));

  // R8: the latched choice does not move while the strobe stays active
  p_hold_in_cycle_r8: assert property (@(posedge cpuClk) disable iff (!rstN)
    ((!memReqN || !ioReqN) && $past(!memReqN || !ioReqN)) |=>
      ((memReqN && ioReqN) || $stable(wantFast)));

  // R6: a fresh I/O cycle asks for the base clock
  p_io_slow_r6: assert property (@(posedge cpuClk) disable iff (!rstN)
    (!ioReqN && $past(memReqN && ioReqN)) |=> !wantFast);

  // R7: a fresh refresh cycle asks for the base clock
  p_refresh_slow_r7: assert property (@(posedge cpuClk) disable iff (!rstN)
    (!memReqN && !refreshN && $past(memReqN && ioReqN)) |=> !wantFast);
endmodule

bind cpu_speed_switch cpu_speed_switch_checker u_chk (
  .clkBase (clkBase),
  .clkFast (clkFast),
  .cpuClk  (cpuClk),
  .rstN    (rstN),
  .memReqN (memReqN),
  .ioReqN  (ioReqN),
  .refreshN(refreshN),
  .laneEn  (laneEn),
  .wantFast(wantFast)
);

// File: tb/sim_cpu_speed_switch.sv
`timescale 1ns/1ps
module sim_cpu_speed_switch;
  localparam real FAST_HALF = 10.0;      // 50 MHz
  localparam real BASE_HALF = 26.4575;   // ratio ~ sqrt(7)
  localparam real MIN_HALF  = 10.0;

  logic clkBase = 1'b0, clkFast = 1'b0;
  logic rstN = 1'b0;
  logic memReqN = 1'b1, ioReqN = 1'b1, refreshN = 1'b1, fastRegion = 1'b0;
  logic cpuClk, fastActive;

  int checks = 0, errors = 0, shortPulses = 0;
  bit monOn = 1'b0;
  real lastEdge = 0.0, minPulse = 1.0e9;
  bit modelFast = 1'b0;   // behavioural selection model

  always #(FAST_HALF) clkFast = ~clkFast;
  always #(BASE_HALF) clkBase = ~clkBase;

  cpu_speed_switch u0 (
    .clkBase(clkBase), .clkFast(clkFast), .rstN(rstN),
    .memReqN(memReqN), .ioReqN(ioReqN), .refreshN(refreshN),
    .fastRegion(fastRegion), .cpuClk(cpuClk), .fastActive(fastActive)
  );

  // R2 pulse-width monitor on every cpuClk transition
  always @(cpuClk) begin
    if (monOn) begin
      real w;
      w = $realtime - lastEdge;
      if (w < minPulse) minPulse = w;
      if (w < MIN_HALF - 0.01) shortPulses++;
    end
    lastEdge = $realtime;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic checkBit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic checkPeriod(string tag, real exp);
    real t0, t1;
    @(posedge cpuClk); t0 = $realtime;
    @(posedge cpuClk); t1 = $realtime;
    checks++;
    if ((t1 - t0) < exp - 0.5 || (t1 - t0) > exp + 0.5) begin
      errors++;
      $display("FAIL %s: actual period %0.3f expected %0.3f", tag, t1 - t0, exp);
    end
  endtask

  // kind: 0 memory, 1 I/O, 2 refresh. flipLate inverts fastRegion and
  // refreshN after the sampling edge while the strobe is still active.
  task automatic busCycle(int kind, bit region, bit flipLate);
    @(negedge cpuClk);
    fastRegion = region;
    memReqN    = (kind == 1);
    ioReqN     = (kind != 1);
    refreshN   = (kind != 2);
    modelFast  = (kind == 0) && region;
    @(posedge cpuClk); #1;
    if (flipLate) begin
      fastRegion = ~region;
      refreshN   = ~refreshN;
    end
    repeat (2) @(negedge cpuClk);
    memReqN = 1'b1; ioReqN = 1'b1; refreshN = 1'b1;
    repeat (16) @(negedge cpuClk);
  endtask

  initial begin
    #(2_000_000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    repeat (20) @(posedge clkBase);
    checkBit("R1 reset status", fastActive, 1'b0);
    @(negedge clkBase); rstN = 1'b1;
    repeat (4) @(negedge cpuClk);
    monOn = 1'b1;
    checkPeriod("R1 base period after reset", 2.0 * BASE_HALF);

    busCycle(0, 1'b1, 1'b0);
    checkBit("R4 fast memory cycle", fastActive, 1'b1);
    checkBit("R10 status matches model", fastActive, modelFast);
    checkPeriod("R4 fast period", 2.0 * FAST_HALF);

    fastRegion = 1'b0;
    repeat (12) @(negedge cpuClk);
    checkBit("R9 idle region change ignored", fastActive, 1'b1);
    checkPeriod("R9 period unchanged", 2.0 * FAST_HALF);

    busCycle(1, 1'b1, 1'b0);
    checkBit("R6 I/O cycle slow", fastActive, 1'b0);
    checkPeriod("R6 base period", 2.0 * BASE_HALF);

    busCycle(0, 1'b1, 1'b0);
    busCycle(2, 1'b1, 1'b0);
    checkBit("R7 refresh cycle slow", fastActive, 1'b0);

    busCycle(0, 1'b1, 1'b0);
    busCycle(0, 1'b0, 1'b0);
    checkBit("R5 slow memory cycle", fastActive, 1'b0);
    checkPeriod("R5 base period", 2.0 * BASE_HALF);

    busCycle(0, 1'b1, 1'b1);
    checkBit("R8 late region drop ignored", fastActive, 1'b1);
    busCycle(0, 1'b0, 1'b1);
    checkBit("R8 late region raise ignored", fastActive, 1'b0);

    for (int n = 0; n < 40; n++) begin
      int k;
      k = int'($urandom_range(2, 0));
      busCycle(k, 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
      checkBit("R10 random cycle vs model", fastActive, modelFast);
    end

    checks++;
    if (shortPulses != 0) begin
      errors++;
      $display("FAIL R2 short pulses: actual %0d (min %0.3f ns) expected 0",
               shortPulses, minPulse);
    end

    summary();
    $finish;
  end
endmodule